// File: doc/BRIEF.md
# Narrow-Bus Converter Result Sequencer

This block is a host-side controller for an 18-bit successive-approximation converter that has a folding parallel output bus. One start request makes it select the converter, keep the read strobe quiet for a guard interval, and pulse convert-start. It then waits for the busy flag to drop. After that it runs one, two or three read cycles, stepping the two fold-select lines through a fixed order. The number of reads depends on the configured host bus width. Each read places some of the result bits into an 18-bit word. The finished word is sent out on a valid/ready output.

All timing is set in nanoseconds and converted to clock counts. The minimum is one cycle, and the read window has one extra cycle so that data is sampled after the enable delay has passed. The output register holds one word. While `out_valid` is high and `out_ready` is low, the word stays frozen and new start requests are ignored. This is the only back-pressure the block applies. `cfg_width` is sampled when a start is accepted. Once a start is accepted it cannot be cancelled. All inputs are taken to be synchronous to `clk`.

Top module: `adcrd_seq`

## Requirements
- R1: While reset is held and just after it, chip-select, convert-start and read strobe are high (inactive), both fold selects are low, and `out_valid` and `timeout_err` are low.
- R2: An accepted start pulls chip-select low before convert-start falls. Convert-start stays low for at least ceil(CONV_LOW_NS/CLK_NS) cycles, and chip-select stays low for that whole time.
- R3: The read strobe is high for at least ceil(QUIET_PRE_NS/CLK_NS) cycles before each convert-start falling edge, and for at least ceil(QUIET_POST_NS/CLK_NS) cycles after it.
- R4: The read strobe goes low only when the busy input is low, after that conversion's busy flag has been seen low.
- R5: With `cfg_width`=00 (18-bit) there is one read with both selects low, and the word is lanes[17:0].
- R6: With `cfg_width`=01 (16-bit) there are two reads. The first has both selects low and gives bits 17..2 from lanes 17..2. The second has byte-select low and width-select high and gives bits 1..0 from lanes 3..2.
- R7: With `cfg_width`=10 or 11 (8-bit) there are three reads. The first has both selects low and gives bits 17..10 from lanes 17..10. The second has byte-select high and width-select low and gives bits 9..2 from lanes 17..10. The third has both selects high and gives bits 1..0 from lanes 11..10.
- R8: A fold-select value never changes while the read strobe is low, or on the same edge as the strobe falls. Successive select changes are at least ceil(SEL_GAP_NS/CLK_NS) cycles apart.
- R9: Each read keeps the strobe low for ceil(RD_EN_NS/CLK_NS)+1 cycles, and lanes are sampled only on the last of those cycles.
- R10: The first DISCARD_N completed conversions after reset (default 3) produce no output word.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged and `start` is ignored (no new convert-start).
- R12: If busy is still high TIMEOUT_CYC cycles after convert-start falls, `timeout_err` pulses for one cycle, chip-select is released, and no word is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion (taken only when idle with no word pending) |
| cfg_width | input | 2 | Host bus width: 00=18, 01=16, 10/11=8 |
| adc_busy | input | 1 | Converter busy flag |
| adc_lanes | input | 18 | Converter data lanes 17..0 |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_convst_n | output | 1 | Convert-start, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_fold_byte | output | 1 | Byte fold select |
| adc_fold_wide | output | 1 | Width fold select |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 18 | Assembled straight-binary result |
| timeout_err | output | 1 | One-cycle pulse on busy timeout |

## Verification
The assertions assume that the converter raises busy no later than the end of the post-convert guard window, and that it holds busy low from the end of a conversion until the next convert-start. The bench converter model follows both rules. Its busy rises one cycle after the convert-start edge and falls a fixed 63 cycles later, or it is held high on purpose only for the timeout case. The model also returns junk on the lanes until the strobe has been low for the enable delay. It counts guard-zone, select-timing and busy-read violations on its own, independently of the checker.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int unsigned DATA_W = 18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_CONV, ST_QUIET, ST_WAIT, ST_SETUP, ST_READ, ST_RECOV
  } seq_state_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // index of the final read for a width code
  function automatic logic [1:0] last_step(input logic [1:0] mode);
    case (mode)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // {byte_sel, wide_sel} for a given read of a given width code
  function automatic logic [1:0] fold_sel(input logic [1:0] mode, input logic [1:0] step);
    if (step == 2'd0) return 2'b00;
    if (mode == 2'b01) return 2'b01;
    return (step == 2'd1) ? 2'b10 : 2'b11;
  endfunction
endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adcrd_asm.sv
module adcrd_asm
  import adcrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [1:0]        mode,
  input  logic [1:0]        step,
  input  logic [DATA_W-1:0] lanes,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned HI = DATA_W - 1;
  localparam int unsigned BL = DATA_W - 8;   // low lane of the top byte

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word <= '0;
    end else if (capture) begin
      case (mode)
        2'b00: word <= lanes;
        2'b01: begin
          if (step == 2'd0) word[HI:2] <= lanes[HI:2];
          else              word[1:0]  <= lanes[3:2];
        end
        default: begin
          case (step)
            2'd0:    word[HI:BL]   <= lanes[HI:BL];
            2'd1:    word[BL-1:2]  <= lanes[HI:BL];
            default: word[1:0]     <= lanes[BL+1:BL];
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int unsigned CLK_NS        = 10,
  parameter int unsigned CONV_LOW_NS   = 40,
  parameter int unsigned QUIET_PRE_NS  = 125,
  parameter int unsigned QUIET_POST_NS = 40,
  parameter int unsigned SEL_SETUP_NS  = 10,
  parameter int unsigned SEL_HOLD_NS   = 10,
  parameter int unsigned SEL_GAP_NS    = 50,
  parameter int unsigned RD_EN_NS      = 30,
  parameter int unsigned RD_HIGH_NS    = 20,
  parameter int unsigned TIMEOUT_CYC   = 200,
  parameter int unsigned DISCARD_N     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_width,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_lanes,
  output logic              adc_cs_n,
  output logic              adc_convst_n,
  output logic              adc_rd_n,
  output logic              adc_fold_byte,
  output logic              adc_fold_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              timeout_err
);
  localparam int unsigned PRE_CYC   = ns2cyc(QUIET_PRE_NS, CLK_NS);
  localparam int unsigned CONV_CYC  = ns2cyc(CONV_LOW_NS, CLK_NS);
  localparam int unsigned POST_CYC  = ns2cyc(QUIET_POST_NS, CLK_NS);
  localparam int unsigned SETUP_CYC = ns2cyc(SEL_SETUP_NS, CLK_NS);
  localparam int unsigned RD_CYC    = ns2cyc(RD_EN_NS, CLK_NS) + 1;
  localparam int unsigned RECOV_CYC = umax(umax(ns2cyc(SEL_HOLD_NS, CLK_NS),
                                                ns2cyc(RD_HIGH_NS, CLK_NS)),
                                           ns2cyc(SEL_GAP_NS, CLK_NS));
  localparam int unsigned MAX_CYC   = umax(umax(umax(PRE_CYC, CONV_CYC), umax(POST_CYC, SETUP_CYC)),
                                           umax(RD_CYC, RECOV_CYC));
  localparam int unsigned TW  = $clog2(MAX_CYC + 1);
  localparam int unsigned TOW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned DCW = $clog2(DISCARD_N + 2);

  seq_state_t        st, st_n;
  logic [1:0]        step, step_n, mode_q;
  logic              tmr_load, tmr_zero, to_load, to_zero;
  logic [TW-1:0]     tmr_val;
  logic              cap, clr, fin, to_fire, accept;
  logic [DCW-1:0]    disc_cnt;
  logic [DATA_W-1:0] word;

  assign accept = (st == ST_IDLE) && start && !out_valid;

  adcrd_timer #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  adcrd_timer #(.W(TOW)) u_watch (
    .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TOW'(TIMEOUT_CYC - 1)), .zero(to_zero)
  );

  adcrd_asm u_asm (
    .clk(clk), .rst_n(rst_n), .clear(clr), .capture(cap),
    .mode(mode_q), .step(step), .lanes(adc_lanes), .word(word)
  );

  always_comb begin
    st_n     = st;
    step_n   = step;
    tmr_load = 1'b0;
    tmr_val  = '0;
    to_load  = 1'b0;
    cap      = 1'b0;
    clr      = 1'b0;
    fin      = 1'b0;
    to_fire  = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        st_n = ST_ARM; tmr_load = 1'b1; tmr_val = TW'(PRE_CYC - 1); clr = 1'b1;
      end
      ST_ARM: if (tmr_zero) begin
        st_n = ST_CONV; tmr_load = 1'b1; tmr_val = TW'(CONV_CYC - 1); to_load = 1'b1;
      end
      ST_CONV: if (tmr_zero) begin
        st_n = ST_QUIET; tmr_load = 1'b1; tmr_val = TW'(POST_CYC - 1);
      end
      ST_QUIET: if (tmr_zero) st_n = ST_WAIT;
      ST_WAIT: begin
        if (!adc_busy) begin
          st_n = ST_SETUP; step_n = 2'd0; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
        end else if (to_zero) begin
          st_n = ST_IDLE; to_fire = 1'b1;
        end
      end
      ST_SETUP: if (tmr_zero) begin
        st_n = ST_READ; tmr_load = 1'b1; tmr_val = TW'(RD_CYC - 1);
      end
      ST_READ: if (tmr_zero) begin
        cap = 1'b1; st_n = ST_RECOV; tmr_load = 1'b1; tmr_val = TW'(RECOV_CYC - 1);
      end
      ST_RECOV: if (tmr_zero) begin
        if (step == last_step(mode_q)) begin
          st_n = ST_IDLE; fin = 1'b1;
        end else begin
          st_n = ST_SETUP; step_n = step + 2'd1;
          tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      step        <= 2'd0;
      mode_q      <= 2'b00;
      out_valid   <= 1'b0;
      out_data    <= '0;
      timeout_err <= 1'b0;
      disc_cnt    <= '0;
    end else begin
      st          <= st_n;
      step        <= step_n;
      timeout_err <= to_fire;
      if (accept) mode_q <= cfg_width;
      if (fin) begin
        if (disc_cnt < DCW'(DISCARD_N)) begin
          disc_cnt <= disc_cnt + 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_data  <= word;
        end
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  logic [1:0] sel;
  assign sel           = (st inside {ST_SETUP, ST_READ, ST_RECOV}) ? fold_sel(mode_q, step) : 2'b00;
  assign adc_fold_byte = sel[1];
  assign adc_fold_wide = sel[0];
  assign adc_cs_n      = (st == ST_IDLE);
  assign adc_convst_n  = (st != ST_CONV);
  assign adc_rd_n      = (st != ST_READ);
endmodule

// File: rtl/adcrd_seq_chk.sv
module adcrd_seq_chk
  import adcrd_pkg::*;
#(
  parameter int unsigned CLK_NS        = 10,
  parameter int unsigned QUIET_PRE_NS  = 125,
  parameter int unsigned QUIET_POST_NS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_cs_n,
  input logic              adc_convst_n,
  input logic              adc_rd_n,
  input logic              adc_fold_byte,
  input logic              adc_fold_wide,
  input logic              adc_busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              timeout_err
);
  localparam int unsigned PRE  = ns2cyc(QUIET_PRE_NS, CLK_NS);
  localparam int unsigned POST = ns2cyc(QUIET_POST_NS, CLK_NS);
  localparam int unsigned CW   = $clog2(umax(PRE, POST) + 2);

  logic [CW-1:0] since_rd, since_cv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rd <= CW'(PRE);
      since_cv <= CW'(POST);
    end else begin
      if (!adc_rd_n)               since_rd <= '0;
      else if (since_rd < CW'(PRE)) since_rd <= since_rd + 1'b1;
      if (!adc_convst_n)            since_cv <= '0;
      else if (since_cv < CW'(POST)) since_cv <= since_cv + 1'b1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) !rst_n |=> adc_cs_n && adc_convst_n && adc_rd_n && !out_valid);
  p_conv_cs_r2:   assert property (@(posedge clk) disable iff (!rst_n) !adc_convst_n |-> !adc_cs_n);
  p_quiet_pre_r3: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_convst_n) |-> since_rd >= CW'(PRE));
  p_quiet_post_r3:assert property (@(posedge clk) disable iff (!rst_n) !adc_rd_n |-> since_cv >= CW'(POST));
  p_read_idle_r4: assert property (@(posedge clk) disable iff (!rst_n) !adc_rd_n |-> !adc_busy && !adc_cs_n);
  p_sel_rdlow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    (!adc_rd_n && $past(!adc_rd_n)) |-> $stable({adc_fold_byte, adc_fold_wide}));
  p_sel_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    $fell(adc_rd_n) |-> $stable({adc_fold_byte, adc_fold_wide}));
  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  p_to_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n) timeout_err |=> !timeout_err);
  p_to_rel_r12:   assert property (@(posedge clk) disable iff (!rst_n) timeout_err |-> adc_cs_n);
endmodule

bind adcrd_seq adcrd_seq_chk #(
  .CLK_NS(CLK_NS), .QUIET_PRE_NS(QUIET_PRE_NS), .QUIET_POST_NS(QUIET_POST_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_convst_n(adc_convst_n),
  .adc_rd_n(adc_rd_n), .adc_fold_byte(adc_fold_byte), .adc_fold_wide(adc_fold_wide),
  .adc_busy(adc_busy), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .timeout_err(timeout_err)
);

// File: tb/adcrd_seq_test.sv
module adcrd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 63;
  localparam int EN_CYC     = 3;
  localparam int PRE_CYC    = 13;
  localparam int POST_CYC   = 4;
  localparam int CONV_CYC   = 4;
  localparam int GAP_CYC    = 5;
  localparam int NVEC       = 8;
  // {width code, converter value}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'b00, 18'h3FFFF}, {2'b00, 18'h00000}, {2'b01, 18'h20000}, {2'b01, 18'h1FFFF},
    {2'b10, 18'h2B5A7}, {2'b10, 18'h00003}, {2'b11, 18'h12345}, {2'b01, 18'h0ABCD}
  };

  logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
  logic [1:0] cfg_width = 2'b00;
  logic busy = 0, stuck = 0;
  logic [17:0] lanes;
  logic cs_n, convst_n, rd_n, fbyte, fwide, out_valid, timeout_err;
  logic [17:0] out_data;

  int errors = 0, checks = 0, cycles = 0;

  adcrd_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .adc_busy(busy),
    .adc_lanes(lanes), .adc_cs_n(cs_n), .adc_convst_n(convst_n), .adc_rd_n(rd_n),
    .adc_fold_byte(fbyte), .adc_fold_wide(fwide), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- converter model ----------------
  logic [17:0] next_val = 0, conv_val = 0;
  logic cv_prev = 1, rd_prev = 1;
  logic [1:0] sel_prev = 0;
  int busy_cnt = 0, rd_low = 0, rd_since = 255, cv_since = 255, sel_age = 255, cv_width = 0;
  int n_conv = 0, n_reads = 0;
  int v_quiet = 0, v_busy = 0, v_sel = 0, v_conv = 0;

  always @(posedge clk) begin
    cv_prev  <= convst_n;
    rd_prev  <= rd_n;
    sel_prev <= {fbyte, fwide};
    rd_low   <= rd_n ? 0 : rd_low + 1;
    rd_since <= !rd_n ? 0 : (rd_since < 255 ? rd_since + 1 : 255);
    cv_since <= (cv_since < 255) ? cv_since + 1 : 255;
    sel_age  <= (sel_age < 255) ? sel_age + 1 : 255;
    if (!convst_n) cv_width <= cv_width + 1;
    if (cv_prev && !convst_n) begin
      if (cs_n) v_conv++;
      if (rd_since < PRE_CYC) v_quiet++;
      conv_val <= next_val; busy <= 1; busy_cnt <= BUSY_CYC;
      cv_since <= 0; n_conv++; n_reads <= 0; cv_width <= 1;
    end else if (busy && !stuck) begin
      if (busy_cnt <= 1) busy <= 0; else busy_cnt <= busy_cnt - 1;
    end else if (busy && stuck) begin
      busy_cnt <= BUSY_CYC;
    end
    if (!cv_prev && convst_n && cv_width < CONV_CYC) v_conv++;
    if (rd_prev && !rd_n) begin
      n_reads <= n_reads + 1;
      if (cv_since < POST_CYC) v_quiet++;
    end
    if (!rd_n && (busy || cs_n)) v_busy++;
    if ({fbyte, fwide} != sel_prev) begin
      if (!rd_n || sel_age < GAP_CYC - 1) v_sel++;
      sel_age <= 0;
    end
    if (!stuck && busy && busy_cnt == 0) busy <= 0;
  end

  always_comb begin
    if (cs_n || rd_n)       lanes = 18'h2AAAA;
    else if (rd_low < EN_CYC) lanes = 18'h15555;
    else case ({fbyte, fwide})
      2'b00:   lanes = conv_val;
      2'b10:   lanes = {conv_val[9:2], 10'h3FF};
      2'b01:   lanes = {14'h3FFF, conv_val[1:0], 2'b11};
      default: lanes = {6'h3F, conv_val[1:0], 10'h3FF};
    endcase
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic pulse_start(input logic [1:0] w, input logic [17:0] v);
    @(negedge clk); cfg_width = w; next_val = v; start = 1;
    @(negedge clk); start = 0;
  endtask

  // runs one conversion to completion; returns 1 if chip-select cycled
  task automatic run_conv(input logic [1:0] w, input logic [17:0] v, output bit done);
    int n;
    pulse_start(w, v);
    n = 0;
    while (!cs_n && n < 3000) begin @(negedge clk); n++; end
    done = (n < 3000);
    @(negedge clk);
  endtask

  function automatic int reads_for(input logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 3;
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    bit done;
    int c0;
    logic [17:0] held;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n && convst_n && rd_n && !fbyte && !fwide && !out_valid && !timeout_err,
          "R1 reset pins", {cs_n, convst_n, rd_n, fbyte, fwide, out_valid, timeout_err}, 7'b1110000);
    rst_n = 1;
    @(negedge clk);
    check(cs_n && convst_n && rd_n && !out_valid, "R1 after reset", {cs_n, convst_n, rd_n, out_valid}, 4'b1110);

    // R10: first three completed conversions are dropped
    for (int i = 0; i < 3; i++) begin
      run_conv(2'b00, 18'h11111 + 18'(i), done);
      check(done && !out_valid, "R10 discard", {done, out_valid}, 2'b10);
    end

    // main table: R5 / R6 / R7 / R9
    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i][19:18], VEC[i][17:0], done);
      check(out_valid, "R5/R6/R7 valid", out_valid, 1);
      check(out_data == VEC[i][17:0],
            (VEC[i][19:18] == 2'b00) ? "R5 word" : (VEC[i][19:18] == 2'b01) ? "R6 word" : "R7 word R9",
            out_data, VEC[i][17:0]);
      check(n_reads == reads_for(VEC[i][19:18]), "R5/R6/R7 read count", n_reads, reads_for(VEC[i][19:18]));
      @(negedge clk); out_ready = 1;
      @(negedge clk); out_ready = 0;
      check(!out_valid, "R11 consume", out_valid, 0);
    end

    // R11: back-pressure holds the word and blocks new starts
    run_conv(2'b10, 18'h3C3C3, done);
    held = out_data;
    c0 = n_conv;
    pulse_start(2'b00, 18'h00001);
    repeat (300) @(negedge clk);
    check(n_conv == c0, "R11 start ignored", n_conv, c0);
    check(out_valid && out_data == held, "R11 word held", out_data, held);
    out_ready = 1; @(negedge clk); out_ready = 0;

    // R12: busy stuck high leads to one-cycle timeout
    begin
      int pulses, n;
      stuck = 1;
      pulse_start(2'b00, 18'h2468A);
      pulses = 0; n = 0;
      while (n < 600) begin
        @(negedge clk);
        if (timeout_err) begin
          pulses++;
          check(cs_n, "R12 cs released", cs_n, 1);
        end
        n++;
      end
      check(pulses == 1, "R12 single pulse", pulses, 1);
      check(!out_valid, "R12 no word", out_valid, 0);
      stuck = 0;
      repeat (5) @(negedge clk);
    end

    // recovery after timeout, boundary code
    run_conv(2'b01, 18'h3FFFF, done);
    check(out_valid && out_data == 18'h3FFFF, "R6 after timeout", out_data, 18'h3FFFF);
    out_ready = 1; @(negedge clk); out_ready = 0;

    // model-side protocol tallies
    check(v_conv == 0, "R2 convert pulse", v_conv, 0);
    check(v_quiet == 0, "R3 quiet zone", v_quiet, 0);
    check(v_busy == 0, "R4 read while busy", v_busy, 0);
    check(v_sel == 0, "R8 select timing", v_sel, 0);
    summary();
  end
endmodule